// File: doc/BRIEF.md
# Move Destination Write Unit

This unit carries out the write half of a register-to-register move. Each cycle in which `valid` is high, it takes a 7-bit destination code, a 16-bit source value and a flag that says whether that source is 8 or 16 bits wide. It decodes the code into one target, converts the width, and either updates an internal register or writes one word to an external data memory.

The register set holds sixteen accumulators, a 4-bit accumulator pointer, eight 8-bit prefix registers, a stack pointer, two loop counters, two data pointers, a frame base pointer with an 8-bit offset, and a general register. Indirect destinations move their pointer first and then write memory at the moved address, all in the same cycle. A load of a prefix register changes how the next move is handled, and only that one move. Prefix register 0 supplies the high byte of a narrow-to-wide transfer. Prefix registers 1 to 7 switch the decode to an extended space that holds the upper accumulator bank and the general register's high byte.

The memory port is word-wide and combinational within the cycle. A side port reads one accumulator so that its contents can be observed, and the other registers appear on dedicated outputs.

Top module: `mv_dst_unit`

## Requirements
- R1: After reset every register is zero, `mem_we` is low and `illegal` is low.
- R2: Code `nnn1001` writes accumulator n (0 to 7) with 16 bits. Code `0001000` loads the accumulator pointer from source bits 3:0. Code `0001010` writes the accumulator that the pointer selects, which may be any of the sixteen.
- R3: A 16-bit target written from an 8-bit source (`src_wide`=0) gets 00h in bits 15:8 and the source low byte in bits 7:0. Code `1101110` writes only bits 7:0 of the general register, from the source low byte, and keeps bits 15:8. Code `1011110` writes the whole general register.
- R4: Code `nnn1011` loads prefix register n from the source low byte. After a load of prefix register 0, the next move alone that has an 8-bit source and a 16-bit target takes its bits 15:8 from that prefix value. The move after it uses 00h again.
- R5: After a load of prefix register 1 to 7, the next move alone is decoded in the extended space. There `nnn1001` writes accumulator 8+n, and `0011110` writes bits 15:8 of the general register from the source low byte. Every other code in the extended space is illegal.
- R6: Code `0001101` adds one to the stack pointer and writes the converted word to memory at the new value. Code `0011101` loads the stack pointer. Code `11n1101` loads loop counter n.
- R7: For codes `nbb1111`, bit 6 selects data pointer n. With bb=00 the unit writes memory at DP[n]. With bb=01 it first adds one to DP[n], and with bb=10 it first subtracts one, then writes memory at the new value. With bb=11 it loads DP[n].
- R8: Codes `0001110`, `0011110` and `0101110` write memory at base pointer plus the zero-extended offset. They keep the offset as it is, add one to it first, or subtract one from it first. Code `0111110` loads the offset from the source low byte, and `1111110` loads the base pointer.
- R9: The stack pointer and the data pointers wrap modulo 2^16, and the offset wraps modulo 2^8.
- R10: Code `1110110` changes no register and writes no memory, but it still uses up a pending prefix.
- R11: In the normal space every code not listed above raises `illegal` during its cycle, for example `0101101` and `1001000`. Such a code causes no register write, no pointer change and no memory write.
- R12: While `valid` is low, nothing changes, `mem_we` stays low and `illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | A move is presented this cycle |
| dst_code | input | 7 | Destination code |
| src_data | input | 16 | Source operand |
| src_wide | input | 1 | 1 when the source is 16 bits, 0 when it is 8 bits |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Data memory word address |
| mem_wdata | output | 16 | Data memory write word |
| illegal | output | 1 | Unrecognised destination this cycle |
| acc_rsel | input | 4 | Accumulator read select |
| acc_rdata | output | 16 | Selected accumulator |
| ap_o | output | 4 | Accumulator pointer |
| sp_o | output | 16 | Stack pointer |
| lc0_o | output | 16 | Loop counter 0 |
| lc1_o | output | 16 | Loop counter 1 |
| dp0_o | output | 16 | Data pointer 0 |
| dp1_o | output | 16 | Data pointer 1 |
| bp_o | output | 16 | Frame base pointer |
| offs_o | output | 8 | Frame offset |
| gr_o | output | 16 | General register |

## Verification
Moves are issued with wide and narrow sources into wide and narrow targets. This tells zero-filling apart from prefix filling, and a byte-lane write apart from a whole-register write. Prefix loads are followed by two moves in a row, which shows whether the effect lasts exactly one instruction and whether index 0 and the other indices act differently. Indirect targets are driven with pointers at 0000h, FFFFh and FFh, which shows that the pointer moves before the access and that the arithmetic wraps. Null, illegal and idle cycles each follow a state that they could disturb, so a stray write shows up on the outputs.

// File: rtl/mv_dst_unit.sv
module mv_dst_unit #(
  parameter int ACC_N = 16,
  parameter int PFX_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [6:0]  dst_code,
  input  logic [15:0] src_data,
  input  logic        src_wide,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic        illegal,
  input  logic [3:0]  acc_rsel,
  output logic [15:0] acc_rdata,
  output logic [3:0]  ap_o,
  output logic [15:0] sp_o,
  output logic [15:0] lc0_o,
  output logic [15:0] lc1_o,
  output logic [15:0] dp0_o,
  output logic [15:0] dp1_o,
  output logic [15:0] bp_o,
  output logic [7:0]  offs_o,
  output logic [15:0] gr_o
);
  localparam int AW = $clog2(ACC_N);

  typedef enum logic [3:0] {
    K_BAD, K_NUL, K_ACC, K_AP, K_PFX, K_PUSH, K_SP, K_LC,
    K_BPM, K_OFFS, K_GR, K_GRL, K_GRH, K_BP, K_DPM, K_DP
  } kind_t;

  logic [15:0] acc_q [ACC_N];
  logic [7:0]  pfx_q [PFX_N];
  logic [AW-1:0] ap_q;
  logic [15:0] sp_q, lc0_q, lc1_q, dp0_q, dp1_q, bp_q, gr_q;
  logic [7:0]  offs_q;
  logic        ext_q, hb_q;

  logic [2:0]  up;
  logic [3:0]  lo;
  kind_t       kind;
  logic [AW-1:0] acc_idx;
  logic        sel;
  logic [1:0]  step;
  logic [15:0] wide_val, dp_cur, dp_nx, sp_nx;
  logic [7:0]  offs_nx;

  assign up = dst_code[6:4];
  assign lo = dst_code[3:0];

  always_comb begin
    kind    = K_BAD;
    acc_idx = '0;
    sel     = 1'b0;
    step    = 2'b00;
    if (ext_q) begin
      if (lo == 4'b1001) begin
        kind    = K_ACC;
        acc_idx = AW'({1'b1, up});
      end else if (dst_code == 7'b0011110) begin
        kind = K_GRH;
      end
    end else begin
      case (lo)
        4'b0110: if (up == 3'd7) kind = K_NUL;
        4'b1000: if (up == 3'd0) kind = K_AP;
        4'b1001: begin
          kind    = K_ACC;
          acc_idx = AW'({1'b0, up});
        end
        4'b1010: if (up == 3'd0) begin
          kind    = K_ACC;
          acc_idx = ap_q;
        end
        4'b1011: kind = K_PFX;
        4'b1101: begin
          case (up)
            3'd0: kind = K_PUSH;
            3'd1: kind = K_SP;
            3'd6, 3'd7: begin
              kind = K_LC;
              sel  = up[0];
            end
            default: kind = K_BAD;
          endcase
        end
        4'b1110: begin
          case (up)
            3'd0: kind = K_BPM;
            3'd1: begin kind = K_BPM; step = 2'b01; end
            3'd2: begin kind = K_BPM; step = 2'b10; end
            3'd3: kind = K_OFFS;
            3'd5: kind = K_GR;
            3'd6: kind = K_GRL;
            3'd7: kind = K_BP;
            default: kind = K_BAD;
          endcase
        end
        4'b1111: begin
          sel  = up[2];
          kind = (up[1:0] == 2'b11) ? K_DP : K_DPM;
          step = (up[1:0] == 2'b11) ? 2'b00 : up[1:0];
        end
        default: kind = K_BAD;
      endcase
    end
  end

  assign wide_val = src_wide ? src_data
                             : {(hb_q ? pfx_q[0] : 8'h00), src_data[7:0]};

  assign dp_cur  = sel ? dp1_q : dp0_q;
  assign dp_nx   = (step == 2'b01) ? dp_cur + 16'd1 :
                   (step == 2'b10) ? dp_cur - 16'd1 : dp_cur;
  assign offs_nx = (step == 2'b01) ? offs_q + 8'd1 :
                   (step == 2'b10) ? offs_q - 8'd1 : offs_q;
  assign sp_nx   = sp_q + 16'd1;

  assign mem_we    = valid && (kind == K_PUSH || kind == K_BPM || kind == K_DPM);
  assign mem_addr  = (kind == K_PUSH) ? sp_nx :
                     (kind == K_BPM)  ? bp_q + {8'h00, offs_nx} : dp_nx;
  assign mem_wdata = wide_val;
  assign illegal   = valid && (kind == K_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ACC_N; i++) acc_q[i] <= '0;
      for (int i = 0; i < PFX_N; i++) pfx_q[i] <= '0;
      ap_q   <= '0;
      sp_q   <= '0;
      lc0_q  <= '0;
      lc1_q  <= '0;
      dp0_q  <= '0;
      dp1_q  <= '0;
      bp_q   <= '0;
      gr_q   <= '0;
      offs_q <= '0;
      ext_q  <= 1'b0;
      hb_q   <= 1'b0;
    end else if (valid) begin
      ext_q <= (kind == K_PFX) && (up != 3'd0);
      hb_q  <= (kind == K_PFX) && (up == 3'd0);
      case (kind)
        K_ACC:  acc_q[acc_idx] <= wide_val;
        K_AP:   ap_q <= src_data[AW-1:0];
        K_PFX:  pfx_q[up] <= src_data[7:0];
        K_PUSH: sp_q <= sp_nx;
        K_SP:   sp_q <= wide_val;
        K_LC:   if (sel) lc1_q <= wide_val; else lc0_q <= wide_val;
        K_BPM:  offs_q <= offs_nx;
        K_OFFS: offs_q <= src_data[7:0];
        K_GR:   gr_q <= wide_val;
        K_GRL:  gr_q[7:0] <= src_data[7:0];
        K_GRH:  gr_q[15:8] <= src_data[7:0];
        K_BP:   bp_q <= wide_val;
        K_DPM:  if (sel) dp1_q <= dp_nx; else dp0_q <= dp_nx;
        K_DP:   if (sel) dp1_q <= wide_val; else dp0_q <= wide_val;
        default: ;
      endcase
    end
  end

  assign acc_rdata = acc_q[acc_rsel];
  assign ap_o   = ap_q;
  assign sp_o   = sp_q;
  assign lc0_o  = lc0_q;
  assign lc1_o  = lc1_q;
  assign dp0_o  = dp0_q;
  assign dp1_o  = dp1_q;
  assign bp_o   = bp_q;
  assign offs_o = offs_q;
  assign gr_o   = gr_q;
endmodule

// File: rtl/mv_dst_unit_chk.sv
module mv_dst_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic [6:0]  dst_code,
  input logic        ext,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        illegal,
  input logic [15:0] sp,
  input logic [15:0] dp0,
  input logic [15:0] dp1,
  input logic [7:0]  offs
);
  // R6
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ext && dst_code == 7'b0001101) |-> (mem_we && mem_addr == sp + 16'd1));

  // R6
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ext && dst_code == 7'b0001101) |=> (sp == $past(sp) + 16'd1));

  // R9
  offs_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ext && dst_code == 7'b0011110) |=> (offs == $past(offs) + 8'd1));

  // R10
  nul_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ext && dst_code == 7'b1110110) |-> (!mem_we && !illegal));

  // R11
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_we);

  // R11
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (sp == $past(sp) && dp0 == $past(dp0) && dp1 == $past(dp1) && offs == $past(offs)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!mem_we && !illegal));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (sp == $past(sp) && dp0 == $past(dp0) && dp1 == $past(dp1) && offs == $past(offs)));
endmodule

bind mv_dst_unit mv_dst_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .dst_code(dst_code), .ext(ext_q),
  .mem_we(mem_we), .mem_addr(mem_addr), .illegal(illegal),
  .sp(sp_q), .dp0(dp0_q), .dp1(dp1_q), .offs(offs_q)
);

// File: tb/sim_mv_dst_unit.sv
`timescale 1ns/1ps
module sim_mv_dst_unit;
  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, src_wide = 1'b0;
  logic [6:0]  dst_code = '0;
  logic [15:0] src_data = '0;
  logic [3:0]  acc_rsel = '0;
  logic        mem_we, illegal;
  logic [15:0] mem_addr, mem_wdata, acc_rdata, sp_o, lc0_o, lc1_o, dp0_o, dp1_o, bp_o, gr_o;
  logic [3:0]  ap_o;
  logic [7:0]  offs_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic last_ill;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  mv_dst_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .dst_code(dst_code), .src_data(src_data),
    .src_wide(src_wide), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .illegal(illegal), .acc_rsel(acc_rsel), .acc_rdata(acc_rdata), .ap_o(ap_o),
    .sp_o(sp_o), .lc0_o(lc0_o), .lc1_o(lc1_o), .dp0_o(dp0_o), .dp1_o(dp1_o),
    .bp_o(bp_o), .offs_o(offs_o), .gr_o(gr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_mem(input logic [15:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic issue(input logic [6:0] c, input logic [15:0] d, input logic w);
    @(posedge clk); #2;
    valid = 1'b1; dst_code = c; src_data = d; src_wide = w;
    #1 last_ill = illegal;
    @(posedge clk); #2;
    valid = 1'b0;
  endtask

  task automatic acc(input logic [3:0] i, output logic [15:0] v);
    acc_rsel = i; #1 v = acc_rdata;
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected memory write", {mem_addr, mem_wdata}, 32'hxxxx_xxxx);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R6/R7/R8 memory write addr,data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1
    acc(4'd0, v); chk("R1 acc0", v, 0);
    chk("R1 sp", sp_o, 0); chk("R1 offs", offs_o, 0); chk("R1 gr", gr_o, 0);
    chk("R1 mem_we", mem_we, 0); chk("R1 illegal", illegal, 0);

    // R2
    issue(7'b0111001, 16'h1234, 1); acc(4'd3, v); chk("R2 A3", v, 16'h1234);
    issue(7'b0001000, 16'h00F3, 0); chk("R2 ap", ap_o, 4'h3);
    issue(7'b0001010, 16'hABCD, 1); acc(4'd3, v); chk("R2 A[ap]", v, 16'hABCD);
    issue(7'b0001000, 16'h000C, 1);
    issue(7'b0001010, 16'h0C0C, 1); acc(4'd12, v); chk("R2 A[ap=12]", v, 16'h0C0C);

    // R3
    issue(7'b0011001, 16'h12FE, 0); acc(4'd1, v); chk("R3 zero fill", v, 16'h00FE);
    issue(7'b1011110, 16'h5678, 1);
    issue(7'b1101110, 16'hFF9A, 1); chk("R3 GRL low byte", gr_o, 16'h569A);

    // R4
    issue(7'b0001011, 16'h0077, 0);
    issue(7'b0101001, 16'h0011, 0); acc(4'd2, v); chk("R4 prefix high byte", v, 16'h7711);
    issue(7'b0101001, 16'h0022, 0); acc(4'd2, v); chk("R4 one-shot", v, 16'h0022);

    // R5
    issue(7'b0011011, 16'h0001, 0);
    issue(7'b0101001, 16'h4444, 1); acc(4'd10, v); chk("R5 A10", v, 16'h4444);
    acc(4'd2, v); chk("R5 A2 untouched", v, 16'h0022);
    issue(7'b0101011, 16'h0002, 0);
    issue(7'b0011110, 16'h00AB, 0); chk("R5 GRH", gr_o, 16'hAB9A);
    chk("R5 offs untouched", offs_o, 8'h00);
    issue(7'b0101001, 16'h5555, 1); acc(4'd2, v); chk("R5 one-shot", v, 16'h5555);
    issue(7'b0011011, 16'h0001, 0);
    issue(7'b0001101, 16'h9999, 1);
    chk("R5 ext push illegal", last_ill, 1); chk("R5 sp kept", sp_o, 0);

    // R6
    issue(7'b0011101, 16'h00FF, 1); chk("R6 sp load", sp_o, 16'h00FF);
    expect_mem(16'h0100, 16'h1357);
    issue(7'b0001101, 16'h1357, 1); chk("R6 sp pre-inc", sp_o, 16'h0100);
    issue(7'b1111101, 16'h2468, 1); chk("R6 lc1", lc1_o, 16'h2468);
    issue(7'b1101101, 16'h0042, 0); chk("R6 lc0", lc0_o, 16'h0042);
    chk("R6 lc1 kept", lc1_o, 16'h2468);

    // R9
    issue(7'b0011101, 16'hFFFF, 1);
    expect_mem(16'h0000, 16'h00C3);
    issue(7'b0001101, 16'h77C3, 0); chk("R9 sp wrap", sp_o, 16'h0000);

    // R7
    issue(7'b1111111, 16'h2000, 1); chk("R7 dp1 load", dp1_o, 16'h2000);
    expect_mem(16'h2001, 16'h0042);
    issue(7'b1011111, 16'h0042, 0); chk("R7 dp1 pre-inc", dp1_o, 16'h2001);
    expect_mem(16'h2000, 16'hBEEF);
    issue(7'b1101111, 16'hBEEF, 1); chk("R7 dp1 pre-dec", dp1_o, 16'h2000);
    expect_mem(16'h2000, 16'h0101);
    issue(7'b1001111, 16'h0101, 1); chk("R7 dp1 plain", dp1_o, 16'h2000);
    issue(7'b0111111, 16'h0000, 1);
    expect_mem(16'hFFFF, 16'h0055);
    issue(7'b0101111, 16'h0055, 1); chk("R9 dp0 wrap", dp0_o, 16'hFFFF);
    chk("R7 dp1 kept", dp1_o, 16'h2000);

    // R8
    issue(7'b1111110, 16'h3000, 1); chk("R8 bp", bp_o, 16'h3000);
    issue(7'b0111110, 16'h12FF, 1); chk("R8 offs load", offs_o, 8'hFF);
    expect_mem(16'h3000, 16'h0A0A);
    issue(7'b0011110, 16'h0A0A, 1); chk("R9 offs wrap", offs_o, 8'h00);
    expect_mem(16'h30FF, 16'h0B0B);
    issue(7'b0101110, 16'h0B0B, 1); chk("R8 offs pre-dec", offs_o, 8'hFF);
    expect_mem(16'h30FF, 16'h0C0C);
    issue(7'b0001110, 16'h0C0C, 1); chk("R8 offs plain", offs_o, 8'hFF);

    // R10
    issue(7'b0001011, 16'h0099, 0);
    issue(7'b1110110, 16'h0001, 1); chk("R10 no illegal", last_ill, 0);
    issue(7'b1011001, 16'h0033, 0); acc(4'd5, v); chk("R10 prefix consumed", v, 16'h0033);

    // R11
    issue(7'b0101101, 16'h1111, 1); chk("R11 iv code illegal", last_ill, 1);
    issue(7'b1001000, 16'h000F, 1); chk("R11 psf code illegal", last_ill, 1);
    chk("R11 ap kept", ap_o, 4'hC); chk("R11 sp kept", sp_o, 16'h0000);

    // R12
    @(posedge clk); #2;
    dst_code = 7'b0001101; src_data = 16'hDEAD; src_wide = 1'b1;
    #1 chk("R12 idle no mem_we", mem_we, 0);
    @(posedge clk); #2;
    chk("R12 sp kept", sp_o, 16'h0000);

    @(posedge clk); #2;
    chk("R6/R7/R8 all writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule